// File: doc/BRIEF.md
# PWM Channel Enable, Status and Event Front End

This block is the shared register front end of a multi-channel PWM peripheral. It decodes a simple memory-mapped request bus into a few global registers and into one fixed-size register window per channel. Each window's accesses are passed to that channel's own waveform logic through a one-hot select. The front end owns each channel's run state. Software sets channels running through a write-one-to-set register and requests them stopped through a write-one-to-clear register.

A stop request does not take effect at once. It is held pending until the channel signals the end of its current period. The channel's enable output and status bit then drop together, so software can poll status to learn that the stop has completed. Period-end pulses from all channels are gathered in an event register that clears when it is read. An event that arrives on the same cycle as that read is kept for the next read.

The channel waveform logic connects through the enable outputs, the period-end pulse inputs and the window access signals. Read data returns one cycle after the request.

Top module: `pwm_front_end`

## Requirements
- R1: After a synchronous reset, every enable output, every status bit and every event bit is zero.
- R2: A write to offset 0x004 starts channel n for every data bit n that is 1. Bits that are 0 leave their channel's state unchanged.
- R3: A write to offset 0x008 requests a stop of channel n for every data bit n that is 1. Bits that are 0 have no effect, and a request aimed at a channel that is already stopped is discarded.
- R4: A requested stop holds the channel's enable output at 1 until a period-end pulse arrives from that channel. The output is 0 from the cycle after that pulse onward.
- R5: A start write to a channel whose stop is still pending cancels the stop, and the channel keeps running through later period ends.
- R6: A read of offset 0x00C returns the run state of channel n in data bit n, with the upper bits zero. It reads 0x0F when four channels run.
- R7: A read of offset 0x01C returns, in bit n, whether channel n has ended a period since the previous read of that offset. The read clears the register.
- R8: A period-end pulse on the same cycle as a read of offset 0x01C is not part of that read's data and appears in the next read.
- R9: Channel n owns offsets 0x200 + n*0x20 to 0x21F + n*0x20. An access there drives select bit n alone, carries address bits [4:0] as the in-window offset and the write flag, and a read returns that channel's read data.
- R10: Reads of any other offset, including the write-only offsets 0x004 and 0x008, return zero. Writes to any other offset change no state.
- R11: Every read request produces a response marked valid on the following cycle, and no other cycle carries a valid response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | DATA_W | Read data |
| ch_en_o | output | NUM_CH | Per-channel run enable to the waveform logic |
| ch_period_end_i | input | NUM_CH | Per-channel one-cycle period-end pulse |
| chan_sel_o | output | NUM_CH | One-hot select of the addressed channel window |
| chan_we_o | output | 1 | Window access is a write |
| chan_off_o | output | 5 | Offset inside the channel window |
| chan_wdata_o | output | DATA_W | Write data forwarded to the window |
| chan_rdata_i | input | NUM_CH*DATA_W | Read data of each channel, channel n in slice n |

## Verification
The bench builds the block with its defaults: four channels, a 12-bit offset and 32-bit data. Four channels make the all-running status value 0x0F reachable, and they put the last window at 0x260, directly below the first unmapped offset 0x280. A 12-bit offset leaves room for random accesses well past the windows. A reference model in the bench tracks run state, pending stops and gathered events. It is driven with directed stop, cancel and read-collision cases and then with random traffic, in which period-end pulses often land on the same cycle as start, stop and event-read accesses.

// File: rtl/pwm_fe_pkg.sv
package pwm_fe_pkg;
  localparam logic [11:0] OFF_START  = 12'h004;
  localparam logic [11:0] OFF_STOP   = 12'h008;
  localparam logic [11:0] OFF_RUNST  = 12'h00C;
  localparam logic [11:0] OFF_EVENT  = 12'h01C;
  localparam logic [11:0] OFF_WIN0   = 12'h200;
  localparam int          WIN_LOG2   = 5;
endpackage

// File: rtl/pwm_fe_decode.sv
module pwm_fe_decode
  import pwm_fe_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                do_start,
  output logic                do_stop,
  output logic                rd_runst,
  output logic                rd_event,
  output logic                rd_win,
  output logic [NUM_CH-1:0]   win_sel,
  output logic [WIN_LOG2-1:0] win_off
);
  localparam int HI_W = ADDR_W - WIN_LOG2;

  logic wr_req, rd_req;
  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;

  assign do_start = wr_req && (req_addr == ADDR_W'(OFF_START));
  assign do_stop  = wr_req && (req_addr == ADDR_W'(OFF_STOP));
  assign rd_runst = rd_req && (req_addr == ADDR_W'(OFF_RUNST));
  assign rd_event = rd_req && (req_addr == ADDR_W'(OFF_EVENT));
  assign win_off  = req_addr[WIN_LOG2-1:0];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_win
    localparam logic [ADDR_W-1:0] WIN_BASE =
      ADDR_W'(OFF_WIN0) + ADDR_W'(n << WIN_LOG2);
    assign win_sel[n] = req_valid &&
      (req_addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
  end

  assign rd_win = rd_req && (|win_sel);

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/pwm_fe_run_bit.sv
module pwm_fe_run_bit (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stop,
  input  logic period_end,
  output logic running,
  output logic stop_pending
);
  logic done, run_n;
  assign done  = stop_pending && period_end;
  assign run_n = start || (running && !done);

  always_ff @(posedge clk) begin
    if (rst) begin
      running      <= 1'b0;
      stop_pending <= 1'b0;
    end else begin
      running      <= run_n;
      stop_pending <= !start && running && !done && ((stop_pending && !period_end) || stop);
    end
  end
endmodule

// File: rtl/pwm_fe_event.sv
module pwm_fe_event #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_clear,
  input  logic [NUM_CH-1:0] period_end,
  output logic [NUM_CH-1:0] events
);
  always_ff @(posedge clk) begin
    if (rst) events <= '0;
    else     events <= (rd_clear ? '0 : events) | period_end;
  end
endmodule

// File: rtl/pwm_front_end.sv
module pwm_front_end
  import pwm_fe_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [NUM_CH-1:0]        ch_en_o,
  input  logic [NUM_CH-1:0]        ch_period_end_i,
  output logic [NUM_CH-1:0]        chan_sel_o,
  output logic                     chan_we_o,
  output logic [WIN_LOG2-1:0]      chan_off_o,
  output logic [DATA_W-1:0]        chan_wdata_o,
  input  logic [NUM_CH*DATA_W-1:0] chan_rdata_i
);
  logic do_start, do_stop, rd_runst, rd_event, rd_win;
  logic [NUM_CH-1:0] win_sel, run_vec, pend_vec, event_vec;
  logic [WIN_LOG2-1:0] win_off;

  pwm_fe_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .do_start  (do_start),
    .do_stop   (do_stop),
    .rd_runst  (rd_runst),
    .rd_event  (rd_event),
    .rd_win    (rd_win),
    .win_sel   (win_sel),
    .win_off   (win_off)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    pwm_fe_run_bit u_run (
      .clk          (clk),
      .rst          (rst),
      .start        (do_start && req_wdata[n]),
      .stop         (do_stop && req_wdata[n]),
      .period_end   (ch_period_end_i[n]),
      .running      (run_vec[n]),
      .stop_pending (pend_vec[n])
    );
  end

  pwm_fe_event #(.NUM_CH(NUM_CH)) u_evt (
    .clk        (clk),
    .rst        (rst),
    .rd_clear   (rd_event),
    .period_end (ch_period_end_i),
    .events     (event_vec)
  );

  assign ch_en_o      = run_vec;
  assign chan_sel_o   = win_sel;
  assign chan_we_o    = req_write && (|win_sel);
  assign chan_off_o   = win_off;
  assign chan_wdata_o = req_wdata;

  logic [DATA_W-1:0] win_rd, rd_mux;
  always_comb begin
    win_rd = '0;
    for (int n = 0; n < NUM_CH; n++)
      if (win_sel[n]) win_rd = win_rd | chan_rdata_i[n*DATA_W +: DATA_W];
  end

  always_comb begin
    rd_mux = '0;
    if (rd_runst)      rd_mux = DATA_W'(run_vec);
    else if (rd_event) rd_mux = DATA_W'(event_vec);
    else if (rd_win)   rd_mux = win_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

  logic unused_pend;
  assign unused_pend = |pend_vec;
endmodule

// File: rtl/pwm_front_end_chk.sv
module pwm_front_end_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [NUM_CH-1:0] ch_en_o,
  input logic [NUM_CH-1:0] ch_period_end_i,
  input logic [NUM_CH-1:0] chan_sel_o,
  input logic [NUM_CH-1:0] event_vec
);
  logic mapped_rd;
  assign mapped_rd = (req_addr == ADDR_W'(12'h00C)) || (req_addr == ADDR_W'(12'h01C)) ||
                     (|chan_sel_o);

  // R2
  start_only_chk: assert property (@(posedge clk) disable iff (rst)
    (|(ch_en_o & ~$past(ch_en_o))) |->
      ($past(req_valid) && $past(req_write) && $past(req_addr) == ADDR_W'(12'h004)));

  // R4
  stop_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    ((~ch_en_o & $past(ch_en_o) & ~$past(ch_period_end_i)) == '0));

  // R7
  event_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (|ch_period_end_i) |=> ((event_vec & $past(ch_period_end_i)) == $past(ch_period_end_i)));

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_sel_o));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !mapped_rd) |=> (rsp_rdata == '0));

  // R11
  rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rsp_valid == $past(req_valid && !req_write)));
endmodule

bind pwm_front_end pwm_front_end_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .req_valid       (req_valid),
  .req_write       (req_write),
  .req_addr        (req_addr),
  .rsp_valid       (rsp_valid),
  .rsp_rdata       (rsp_rdata),
  .ch_en_o         (ch_en_o),
  .ch_period_end_i (ch_period_end_i),
  .chan_sel_o      (chan_sel_o),
  .event_vec       (event_vec)
);

// File: tb/pwm_front_end_tb_top.sv
module pwm_front_end_tb_top;
  localparam int NCH = 4;
  localparam int AW  = 12;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [NCH-1:0] ch_en_o, chan_sel_o;
  logic [NCH-1:0] pe = '0;
  logic chan_we_o;
  logic [4:0] chan_off_o;
  logic [DW-1:0] chan_wdata_o;
  logic [NCH*DW-1:0] chan_rdata;

  always #2 clk = ~clk;

  for (genvar n = 0; n < NCH; n++) begin : g_stub
    assign chan_rdata[n*DW +: DW] = 32'hA000_0000 | (n << 8) | 32'(chan_off_o);
  end

  pwm_front_end #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ch_en_o(ch_en_o), .ch_period_end_i(pe),
    .chan_sel_o(chan_sel_o), .chan_we_o(chan_we_o), .chan_off_o(chan_off_o),
    .chan_wdata_o(chan_wdata_o), .chan_rdata_i(chan_rdata)
  );

  int checks = 0, errors = 0;
  logic [NCH-1:0] m_run = '0, m_pend = '0, m_evt = '0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int win_of(logic [AW-1:0] a);
    if (a >= 12'h200 && a < 12'h200 + NCH*32) return (int'(a) - 32'h200) >> 5;
    return -1;
  endfunction

  function automatic logic [31:0] exp_read(logic [AW-1:0] a);
    int w = win_of(a);
    if (a == 12'h00C) return 32'(m_run);
    if (a == 12'h01C) return 32'(m_evt);
    if (w >= 0) return 32'hA000_0000 | (w << 8) | 32'(a[4:0]);
    return 32'h0;
  endfunction

  function automatic string rd_tag(logic [AW-1:0] a);
    if (a == 12'h00C) return "R6";
    if (a == 12'h01C) return "R7";
    if (win_of(a) >= 0) return "R9";
    return "R10";
  endfunction

  // one bus cycle: drive at negedge, check after the following edge
  task automatic step(bit v, bit w, logic [AW-1:0] a, logic [31:0] d,
                      logic [NCH-1:0] p, string tag);
    logic [31:0] er;
    logic [NCH-1:0] st, sp, done, nrun;
    int wi;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; pe = p;
    #1;
    wi = win_of(a);
    if (v && wi >= 0) begin
      check("R9 sel", 32'(chan_sel_o), 32'(1 << wi));
      check("R9 off", 32'(chan_off_o), 32'(a[4:0]));
      check("R9 we", 32'(chan_we_o), 32'(w));
    end
    er = exp_read(a);
    st = (v && w && a == 12'h004) ? d[NCH-1:0] : '0;
    sp = (v && w && a == 12'h008) ? d[NCH-1:0] : '0;
    done = m_pend & p;
    nrun = st | (m_run & ~done);
    m_pend = ~st & m_run & ~done & ((m_pend & ~p) | sp);
    m_run = nrun;
    m_evt = ((v && !w && a == 12'h01C) ? '0 : m_evt) | p;
    @(posedge clk);
    @(negedge clk);
    check(tag, 32'(ch_en_o), 32'(m_run));
    check("R11", 32'(rsp_valid), 32'(v && !w));
    if (v && !w) check(rd_tag(a), rsp_rdata, er);
  endtask

  task automatic idle(logic [NCH-1:0] p, string tag);
    step(0, 0, '0, '0, p, tag);
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", 32'(ch_en_o), 0);
    step(1, 0, 12'h00C, 0, 0, "R1");
    step(1, 0, 12'h01C, 0, 0, "R1");
    // R2 start with set bits, zeros harmless
    step(1, 1, 12'h004, 32'h5, 0, "R2");
    step(1, 1, 12'h004, 32'h0, 0, "R2");
    step(1, 1, 12'h004, 32'hA, 0, "R2");
    step(1, 0, 12'h00C, 0, 0, "R6");
    // R3/R4 deferred stop
    step(1, 1, 12'h008, 32'h1, 0, "R4");
    idle(0, "R4");
    idle(4'h2, "R4");
    idle(4'h1, "R4");
    step(1, 0, 12'h00C, 0, 0, "R4");
    step(1, 1, 12'h008, 32'h0, 0, "R3");
    step(1, 1, 12'h008, 32'h1, 0, "R3");
    step(1, 1, 12'h004, 32'h1, 0, "R3");
    idle(4'h1, "R3");
    // R5 cancel by start
    step(1, 1, 12'h008, 32'h2, 0, "R5");
    step(1, 1, 12'h004, 32'h2, 0, "R5");
    idle(4'h2, "R5");
    idle(4'h2, "R5");
    // R7/R8 events and read collision
    step(1, 0, 12'h01C, 0, 0, "R7");
    step(1, 0, 12'h01C, 0, 4'h4, "R8");
    step(1, 0, 12'h01C, 0, 0, "R8");
    step(1, 0, 12'h01C, 0, 0, "R7");
    // R9 windows
    step(1, 0, 12'h200, 0, 0, "R9");
    step(1, 0, 12'h224, 0, 0, "R9");
    step(1, 0, 12'h27C, 0, 0, "R9");
    step(1, 1, 12'h240, 32'h1234, 0, "R9");
    // R10 unmapped
    step(1, 0, 12'h280, 0, 0, "R10");
    step(1, 0, 12'h010, 0, 0, "R10");
    step(1, 0, 12'h004, 0, 0, "R10");
    step(1, 0, 12'h008, 0, 0, "R10");
    step(1, 1, 12'h00C, 32'hF, 0, "R10");
    step(1, 1, 12'h01C, 32'hF, 0, "R10");
    step(1, 0, 12'h00C, 0, 0, "R10");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [NCH-1:0] p;
      int sel = $urandom_range(0, 7);
      case (sel)
        0, 1: a = 12'h004;
        2, 3: a = 12'h008;
        4:    a = 12'h00C;
        5:    a = 12'h01C;
        6:    a = 12'h200 + AW'($urandom_range(0, NCH*32-1));
        default: a = AW'($urandom);
      endcase
      p = ($urandom_range(0, 2) == 0) ? NCH'($urandom) : '0;
      step($urandom_range(0, 3) != 0, (sel < 4) ? 1'b1 : 1'(($urandom_range(0, 5) == 0)),
           a, $urandom, p, "R4");
    end
    finish_up();
  end
endmodule